// File: doc/BRIEF.md
# Programmable-Priority DMA Channel Arbiter

This block decides which DMA channel owns the shared bus for the next beat. It serves twelve channels split between two controllers: controller A has seven channels and controller B has five. Each channel presents a request, an enable and a 2-bit priority level that software programs. On each arbitration the eligible channel with the highest level wins. A tie on level goes to controller A over controller B, and inside one controller to the lower channel number.

The winner is registered as a one-hot grant vector, a flat winner index and a valid flag. A grant stays in place until the bus acknowledges the granted beat. Arbitration then runs again in the acknowledging cycle, and the new winner appears after the next clock edge. While no grant is held, the block arbitrates on every cycle.

Top module: `dma_prio_arbiter`

## Requirements
- R1: At most one bit of `grant` is set. When `grant_vld` is high, `grant` has exactly the bit `grant_idx` set. When `grant_vld` is low, `grant` and `grant_idx` are zero.
- R2: Priority levels are encoded 0 = low, 1 = medium, 2 = high, 3 = very high. An eligible channel with a higher level always beats one with a lower level, whatever its controller or number.
- R3: Among eligible channels of one controller that share the top level, the lowest channel number wins.
- R4: Flat numbering puts controller A channel k at index k and bit k, and controller B channel k at index 7+k and bit 7+k. When the top level is shared across both controllers, a controller A channel wins.
- R5: A channel whose enable is low, or whose request is low, never receives a grant.
- R6: If no channel is eligible at arbitration, the next cycle shows `grant_vld` low and `grant` all zeros.
- R7: Arbitration happens in every cycle where `grant_vld` is low or `beat_ack` is high, and its result is registered at that clock edge. While `grant_vld` is high and `beat_ack` is low, `grant` and `grant_idx` hold.
- R8: Levels and requests are sampled only at arbitration. A level change while a grant is held has no effect until the next arbitration.
- R9: After reset, `grant_vld` is low and `grant` and `grant_idx` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_a | input | 7 | Controller A channel requests, bit k = channel k |
| en_a | input | 7 | Controller A channel enables |
| lvl_a | input | 14 | Controller A levels, bits [2k+1:2k] for channel k |
| req_b | input | 5 | Controller B channel requests |
| en_b | input | 5 | Controller B channel enables |
| lvl_b | input | 10 | Controller B levels, bits [2k+1:2k] for channel k |
| beat_ack | input | 1 | Granted beat completed; re-arbitrate |
| grant | output | 12 | One-hot grant in flat numbering |
| grant_idx | output | 4 | Flat index of the granted channel |
| grant_vld | output | 1 | A grant is held |

## Verification
Several properties are checked on every cycle:
- the grant is one-hot and matches the index and valid flag;
- a grant holds until it is acknowledged;
- a new grant always goes to a channel that was requesting and enabled at the arbitration edge;
- the outputs are empty when nothing is valid.

The ordering decisions can only be shown by the bench scenarios: level beating index, the tie rules within and across controllers, and the deferred effect of a level change. The bench compares each of these against a level-first reference search, over directed cases and a stream of pseudo-random patterns.

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int N_A = 7,
  parameter int N_B = 5,
  parameter int LW  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_A-1:0]               req_a,
  input  logic [N_A-1:0]               en_a,
  input  logic [N_A*LW-1:0]            lvl_a,
  input  logic [N_B-1:0]               req_b,
  input  logic [N_B-1:0]               en_b,
  input  logic [N_B*LW-1:0]            lvl_b,
  input  logic                         beat_ack,
  output logic [N_A+N_B-1:0]           grant,
  output logic [$clog2(N_A+N_B)-1:0]   grant_idx,
  output logic                         grant_vld
);
  localparam int N  = N_A + N_B;
  localparam int IW = $clog2(N);

  logic [N-1:0]    elig;
  logic [N*LW-1:0] lvl_all;
  logic [IW-1:0]   best_idx;
  logic [LW-1:0]   best_lvl;
  logic            found;
  logic            arb_go;

  assign elig    = {req_b & en_b, req_a & en_a};
  assign lvl_all = {lvl_b, lvl_a};
  assign arb_go  = !grant_vld || beat_ack;

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    best_idx = '0;
    best_lvl = '0;
    found    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i] && (!found || lvl_all[i*LW +: LW] >= best_lvl)) begin
        best_idx = IW'(i);
        best_lvl = lvl_all[i*LW +: LW];
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant     <= '0;
      grant_idx <= '0;
      grant_vld <= 1'b0;
    end else if (arb_go) begin
      grant_vld <= found;
      grant     <= found ? (N'(1) << best_idx) : '0;
      grant_idx <= found ? best_idx : '0;
    end
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r1_idx_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> grant[grant_idx]);
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld |-> (grant == '0 && grant_idx == '0));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !beat_ack) |=> ($stable(grant) && $stable(grant_idx) && grant_vld));
  a_r5_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    arb_go |=> ((grant & ~$past(elig)) == '0));
endmodule

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;
  localparam int NA = 7, NB = 5, LW = 2, N = NA + NB, IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic [N-1:0]    req = '0, en = '0;
  logic [N*LW-1:0] lvl = '0;
  logic            beat_ack = 0;
  logic [N-1:0]    grant;
  logic [IW-1:0]   grant_idx;
  logic            grant_vld;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dma_prio_arbiter u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_a(req[NA-1:0]), .en_a(en[NA-1:0]), .lvl_a(lvl[NA*LW-1:0]),
    .req_b(req[N-1:NA]), .en_b(en[N-1:NA]), .lvl_b(lvl[N*LW-1:NA*LW]),
    .beat_ack(beat_ack),
    .grant(grant), .grant_idx(grant_idx), .grant_vld(grant_vld));

  // Reference: highest level first, then lowest flat index.
  function automatic int ref_win(input logic [N-1:0] r, input logic [N-1:0] e,
                                 input logic [N*LW-1:0] l);
    for (int lv = 3; lv >= 0; lv--)
      for (int i = 0; i < N; i++)
        if (r[i] && e[i] && l[i*LW +: LW] == lv) return i;
    return -1;
  endfunction

  task automatic expect_win(input int exp, input string req_tag);
    logic [N-1:0] eg = (exp < 0) ? '0 : (N'(1) << exp);
    logic [IW-1:0] ei = (exp < 0) ? '0 : IW'(exp);
    checks++;
    if (grant !== eg || grant_idx !== ei || grant_vld !== (exp >= 0)) begin
      errors++;
      $display("FAIL %s: grant=%b idx=%0d vld=%b expected grant=%b idx=%0d vld=%b",
               req_tag, grant, grant_idx, grant_vld, eg, ei, exp >= 0);
    end
  endtask

  function automatic logic [N*LW-1:0] set_lvl(input logic [N*LW-1:0] l, input int ch,
                                             input int v);
    logic [N*LW-1:0] t = l;
    t[ch*LW +: LW] = LW'(v);
    return t;
  endfunction

  // Apply a pattern with an acknowledge, then check after the next edge.
  task automatic arb(input logic [N-1:0] r, input logic [N-1:0] e,
                     input logic [N*LW-1:0] l, input string tag);
    @(negedge clk);
    req = r; en = e; lvl = l; beat_ack = 1;
    @(negedge clk);
    beat_ack = 0;
    expect_win(ref_win(r, e, l), tag);
  endtask

  task automatic t_reset;
    expect_win(-1, "R9 reset");
  endtask

  task automatic t_idle;
    arb('0, '1, '0, "R6 no requests");
    arb(12'h0FF, '0, '1, "R6 all disabled");
  endtask

  task automatic t_level;
    logic [N*LW-1:0] l = '0;
    l = set_lvl(l, 0, 1); l = set_lvl(l, 11, 3);
    arb(12'h801, '1, l, "R2 very high B4 beats medium A0");
    expect_win(11, "R2 explicit");
    l = '0; l = set_lvl(l, 3, 2); l = set_lvl(l, 1, 1);
    arb(12'h00A, '1, l, "R2 high A3 beats medium A1");
    expect_win(3, "R2 explicit 2");
  endtask

  task automatic t_tie_same;
    logic [N*LW-1:0] l = '0;
    l = set_lvl(l, 2, 2); l = set_lvl(l, 5, 2);
    arb(12'h024, '1, l, "R3 A2 vs A5");
    expect_win(2, "R3 A2 explicit");
    l = '0; l = set_lvl(l, 8, 1); l = set_lvl(l, 10, 1);
    arb(12'h500, '1, l, "R3 B1 vs B3");
    expect_win(8, "R3 B1 explicit");
  endtask

  task automatic t_tie_cross;
    logic [N*LW-1:0] l = '0;
    l = set_lvl(l, 6, 1); l = set_lvl(l, 7, 1);
    arb(12'h0C0, '1, l, "R4 A6 vs B0");
    expect_win(6, "R4 A6 explicit");
  endtask

  task automatic t_disabled;
    logic [N*LW-1:0] l = '0;
    l = set_lvl(l, 0, 3);
    arb(12'h003, 12'hFFE, l, "R5 disabled A0 skipped");
    expect_win(1, "R5 A1 explicit");
    arb(12'h002, 12'h001, l, "R5 enabled but idle A0 skipped");
    expect_win(-1, "R5 nothing explicit");
  endtask

  task automatic t_hold;
    logic [N*LW-1:0] l = '0;
    arb(12'h002, '1, l, "R7 first grant");
    @(negedge clk);
    req = '1; lvl = '1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      expect_win(1, "R8 level change ignored while held");
    end
    beat_ack = 1;
    @(negedge clk);
    beat_ack = 0;
    expect_win(0, "R7 re-arbitration after ack");
    @(negedge clk);
    req = '0; beat_ack = 1;
    @(negedge clk);
    beat_ack = 0;
    expect_win(-1, "R6 ack with nothing pending");
  endtask

  task automatic t_random;
    int unsigned s = 32'h1234_5678;
    for (int k = 0; k < 200; k++) begin
      logic [N-1:0] r, e;
      logic [N*LW-1:0] l;
      s = s * 1103515245 + 12345; r = N'(s >> 7);
      s = s * 1103515245 + 12345; e = N'(s >> 5);
      s = s * 1103515245 + 12345; l = (N*LW)'(s);
      arb(r, e, l, "R2 R3 R4 R5 random");
    end
  endtask

  initial begin
    #10 t_reset();
    @(negedge clk); rst_n = 1;
    @(negedge clk); expect_win(-1, "R9 after release");
    t_idle(); t_level(); t_tie_same(); t_tie_cross();
    t_disabled(); t_hold(); t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule